// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two eight-bit buses, called A and B, and moves data between them in either direction or in both at once. Each direction owns a capture register. The A-to-B register takes a copy of the A bus on the rising edge of its capture strobe, and the B-to-A register does the same for the B bus. Both strobes are asynchronous to the system clock. Each one passes through a synchronizer and an edge detector before it loads its register. A register loads on every recognised strobe edge, whatever the state of the port enables and source selects.

Each bus port has its own source select. The select chooses between the live value on the opposite bus and the value held in that direction's register. The port then drives the bitwise inverse of the chosen value. A direction input lets the B port drive, and a separate active-low enable lets the A port drive. Tri-state pads are modelled as separate input, output and output-enable vectors for each port.

When both ports drive and both selects are in live mode, each bus is driven from the inverse of the other. The two buses then form a latch, and they keep their last values once every external driver has let go.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When the A-to-B capture strobe rises, the A-to-B register takes the A bus value, provided the A bus is held stable for the three clock cycles after the rise. The new value becomes visible on a port within three clock cycles.
- R2: When the B-to-A capture strobe rises, the B-to-A register takes the B bus value, under the same conditions and within the same time as R1.
- R3: A register loads on a strobe rise even when both ports are disabled and whatever the source selects are.
- R4: A register does not change while its strobe stays high or stays low, even if the bus it samples changes.
- R5: Reset clears both registers to zero. After reset, a port that selects its stored value drives 8'hFF.
- R6: The B port source select works as follows: a value of 0 picks the live A bus, and a value of 1 picks the A-to-B register. The A port select picks the live B bus or the B-to-A register in the same way.
- R7: `b_oe` is all ones exactly when `dir_b` is 1, and it is all zeros otherwise.
- R8: `a_oe` is all ones exactly when `a_en_n` is 0, and it is all zeros otherwise.
- R9: The data on a port output is the bitwise inverse of the selected source.
- R10: Set `dir_b` to 1, `a_en_n` to 0 and both selects to 0. Once the external drivers release, the A bus and the B bus keep their last values, and these stay bitwise inverses of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, and is released synchronously outside the block |
| a_in | input | 8 | Resolved value of the A bus |
| a_out | output | 8 | Data driven onto the A bus |
| a_oe | output | 8 | Output enables for the A bus |
| b_in | input | 8 | Resolved value of the B bus |
| b_out | output | 8 | Data driven onto the B bus |
| b_oe | output | 8 | Output enables for the B bus |
| stb_ab | input | 1 | A-to-B capture strobe (asynchronous) |
| stb_ba | input | 1 | B-to-A capture strobe (asynchronous) |
| dir_b | input | 1 | When 1, the B port drives |
| a_en_n | input | 1 | When 0, the A port drives |
| sel_ab | input | 1 | B port source: 0 = live A bus, 1 = A-to-B register |
| sel_ba | input | 1 | A port source: 0 = live B bus, 1 = B-to-A register |

## Verification
The register checks assume that the bus value a strobe captures does not change during the cycles it takes the strobe to cross the synchronizer. The stimulus therefore holds each bus steady from before the strobe rises until several cycles after it. The checks that compare live outputs assume the bus inputs are settled within a cycle. The bench resolves each bus and iterates the resolution a few times after every change, so that in loopback mode the two buses reach their consistent pair before anything is sampled. The bench never lets an external driver oppose an enabled port, and it counts any such contention as a failure.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Source choice for a port's output multiplexer.
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], stb};
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4
endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R1
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R4
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  src_sel_e         sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] oe
);
  logic [WIDTH-1:0] chosen;

  always_comb begin
    chosen = (sel == SRC_HELD) ? held : live;
    out    = ~chosen;
    oe     = {WIDTH{en}};
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             stb_ab,
  input  logic             stb_ba,
  input  logic             dir_b,
  input  logic             a_en_n,
  input  logic             sel_ab,
  input  logic             sel_ba
);
  logic             rise_ab, rise_ba;
  logic [WIDTH-1:0] ab_q, ba_q;

  xcvr_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_ab (
    .clk(clk), .rst_n(rst_n), .stb(stb_ab), .rise(rise_ab));
  xcvr_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_ba (
    .clk(clk), .rst_n(rst_n), .stb(stb_ba), .rise(rise_ba));

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .load(rise_ab), .d(a_in), .q(ab_q));
  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .load(rise_ba), .d(b_in), .q(ba_q));

  xcvr_port_drive #(.WIDTH(WIDTH)) u_drv_b (
    .en(dir_b), .sel(src_sel_e'(sel_ab)), .live(a_in), .held(ab_q),
    .out(b_out), .oe(b_oe));
  xcvr_port_drive #(.WIDTH(WIDTH)) u_drv_a (
    .en(~a_en_n), .sel(src_sel_e'(sel_ba)), .live(b_in), .held(ba_q),
    .out(a_out), .oe(a_oe));

  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_b && a_en_n) |-> (a_oe == '0 && b_oe == '0)); // R7
  AST_B_LIVE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ab) |-> (b_out == ~a_in)); // R9
  AST_A_HELD_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ba && $stable(sel_ba) && !$past(rise_ba)) |-> (a_out == ~$past(~a_out))); // R6
endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int PERIOD = 10;
  localparam int W      = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic stb_ab, stb_ba, dir_b, a_en_n, sel_ab, sel_ba;
  logic [W-1:0] ext_a, ext_b;
  logic ext_a_on, ext_b_on;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .stb_ab(stb_ab), .stb_ba(stb_ba),
    .dir_b(dir_b), .a_en_n(a_en_n), .sel_ab(sel_ab), .sel_ba(sel_ba));

  // Resolve both buses; iterate so the loopback pair settles.
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      if (a_oe[0]) a_in = a_out; else if (ext_a_on) a_in = ext_a;
      if (b_oe[0]) b_in = b_out; else if (ext_b_on) b_in = ext_b;
      if (a_oe[0] && ext_a_on && a_out != ext_a) begin
        n_fail++; $display("FAIL R8 contention on A: %h vs %h", a_out, ext_a);
      end
      if (b_oe[0] && ext_b_on && b_out != ext_b) begin
        n_fail++; $display("FAIL R7 contention on B: %h vs %h", b_out, ext_b);
      end
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    settle();
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    stb_ab = 1'b1; step(4); stb_ab = 1'b0; step(4);
  endtask
  task automatic pulse_ba();
    stb_ba = 1'b1; step(4); stb_ba = 1'b0; step(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stb_ab = 0; stb_ba = 0; dir_b = 0; a_en_n = 1;
    sel_ab = 0; sel_ba = 0; ext_a_on = 1; ext_b_on = 1;
    ext_a = 8'h00; ext_b = 8'h00; a_in = 0; b_in = 0;
    step(3);
    rst_n = 1'b1; step(2);
    chk("R7 b_oe idle", b_oe, 8'h00);
    chk("R8 a_oe idle", a_oe, 8'h00);
    // Show stored values while the external drivers release.
    ext_a_on = 0; ext_b_on = 0; sel_ab = 1; sel_ba = 1; dir_b = 1; a_en_n = 0;
    step(1);
    chk("R5 b_out from cleared reg", b_out, 8'hFF);
    chk("R5 a_out from cleared reg", a_out, 8'hFF);
    dir_b = 0; a_en_n = 1; ext_a_on = 1; ext_b_on = 1; step(1);
  endtask

  task automatic t_live();
    sel_ab = 0; sel_ba = 0;
    dir_b = 1; a_en_n = 1; ext_a = 8'h5A; ext_b_on = 0; step(1);
    chk("R7 b_oe dir", b_oe, 8'hFF);
    chk("R8 a_oe off", a_oe, 8'h00);
    chk("R9 R6 b_out live", b_out, 8'hA5);
    chk("R9 b bus", b_in, 8'hA5);
    dir_b = 0; ext_b_on = 1; ext_b = 8'h81; step(1);
    a_en_n = 0; ext_a_on = 0; step(1);
    chk("R8 a_oe on", a_oe, 8'hFF);
    chk("R7 b_oe off", b_oe, 8'h00);
    chk("R9 R6 a_out live", a_out, 8'h7E);
    a_en_n = 1; ext_a_on = 1; step(1);
  endtask

  task automatic t_capture_isolated();
    dir_b = 0; a_en_n = 1; sel_ab = 1; sel_ba = 1;
    ext_a = 8'h3C; ext_b = 8'hC9; step(1);
    pulse_ab(); pulse_ba();
    ext_a = 8'h11; ext_b = 8'h22; step(1);
    dir_b = 1; ext_b_on = 0; step(1);
    chk("R1 R3 A-to-B stored", b_out, 8'hC3);
    dir_b = 0; ext_b_on = 1; step(1);
    a_en_n = 0; ext_a_on = 0; step(1);
    chk("R2 R3 B-to-A stored", a_out, 8'h36);
    a_en_n = 1; ext_a_on = 1; step(1);
  endtask

  task automatic t_level_hold();
    sel_ab = 1; dir_b = 1; ext_b_on = 0; ext_a = 8'hE7; step(1);
    stb_ab = 1'b1; step(5);
    chk("R1 new capture", b_out, 8'h18);
    ext_a = 8'h42; step(4);
    chk("R4 no reload while high", b_out, 8'h18);
    stb_ab = 1'b0; step(4);
    chk("R4 no load on fall", b_out, 8'h18);
    sel_ab = 0; step(1);
    chk("R6 back to live", b_out, 8'hBD);
    dir_b = 0; ext_b_on = 1; step(1);
  endtask

  task automatic t_loopback();
    sel_ab = 0; sel_ba = 0; ext_a = 8'h96; dir_b = 1; ext_b_on = 0; step(1);
    a_en_n = 0; ext_a_on = 0; step(3);
    chk("R10 A holds", a_in, 8'h96);
    chk("R10 B holds", b_in, 8'h69);
    step(4);
    chk("R10 A still holds", a_in, 8'h96);
    chk("R10 B inverse", b_in, ~a_in);
  endtask

  initial begin
    t_reset();
    t_live();
    t_capture_isolated();
    t_level_hold();
    t_loopback();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule